// File: doc/BRIEF.md
# Configurable Pad I/O Cell Bank

This block is a bank of per-pad I/O cells, one cell for each pad. Each cell holds a small configuration word. The word chooses whether the pad behaves as a plain input, a driven output, or a bidirectional pin whose three-state enable is switched by logic. It also chooses how the cell drives the pad: a push-pull driver that drives both levels, or an open-drain driver that only pulls low and leaves the high level to an external pull-up.

In bidirectional use, the enable comes from one of three sources. The first is the cell's own product-term enable from the logic array, which is active high. The other two are chip-wide enables, which are active low. Whatever the pad is doing, its level is passed straight back to the internal routing, so logic anywhere on the chip can read it.

The configuration of each cell is loaded on a clock edge through a per-pin write strobe. Reset returns every cell to the erased state, in which every configuration bit is 1. The pad model consists of three signals per pin: the driven value, the drive enable and the received value.

Top module: `iocell_bank`

## Requirements
- R1: After reset, every cell holds the erased word, which has all bits set to 1. That word means input mode, product-term source and push-pull drive, so `pad_oe` is 0 and `pad_o` follows `dout`.
- R2: The configuration word of pin i is bits [4:3] direction, bits [2:1] enable source and bit [0] drive type. A clock edge with `cfg_we[i]`=1 loads `cfg_din` into pin i. The new setting is in effect after that edge. Pins whose strobe is 0 keep their word.
- R3: Direction 00 and direction 11 are input mode. In input mode `pad_oe` is 0, whatever the values of `pt_oe`, `goe_n` and `dout`.
- R4: Direction 01 is output mode. The cell enable is always on, whatever the source field holds.
- R5: Direction 10 is bidirectional mode. The cell enable equals the source that the source field selects.
- R6: The source field selects the enable as follows. 11 selects `pt_oe[i]`, active high. 01 selects `goe_n[0]` and 10 selects `goe_n[1]`, both active low. 00 never enables. Sources that are not selected have no effect.
- R7: When the drive bit is 1 (push-pull), `pad_oe` equals the cell enable and `pad_o` equals `dout[i]`.
- R8: When the drive bit is 0 (open-drain), `pad_o` is 0. `pad_oe` is 1 only when the cell enable is on and `dout[i]` is 0.
- R9: `route_o[i]` equals `pad_i[i]` in every mode, including while the cell drives the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset to the erased word |
| cfg_we | input | NUM_PINS | Per-pin configuration write strobe |
| cfg_din | input | 5 | Configuration word: {direction, source, drive} |
| goe_n | input | 2 | Chip-wide output enables, active low |
| pt_oe | input | NUM_PINS | Per-pin product-term output enable, active high |
| dout | input | NUM_PINS | Per-pin data to drive |
| pad_i | input | NUM_PINS | Level received from each pad |
| pad_o | output | NUM_PINS | Value driven onto each pad |
| pad_oe | output | NUM_PINS | Drive enable for each pad |
| route_o | output | NUM_PINS | Pad level returned to internal routing |

## Verification
The bench builds the bank with NUM_PINS set to 3. With three pins, each pin can hold a different direction and drive type at the same time. This makes it possible to observe that a strobe on one pin leaves its neighbours' words untouched, and that the shared global enables act only on the pins that select them. Three pins is also enough to check every source encoding on one pin while the other two stay in input and output modes.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  localparam int GOE_COUNT = 2;

  typedef enum logic [1:0] {
    DIR_IN_ALT = 2'b00,
    DIR_OUT    = 2'b01,
    DIR_BIDIR  = 2'b10,
    DIR_IN     = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_G0  = 2'b01,
    SRC_G1  = 2'b10,
    SRC_PT  = 2'b11
  } src_e;

  typedef struct packed {
    dir_e dir;
    src_e src;
    logic push_pull;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

  // Erased fuse state: every bit reads as one.
  localparam cell_cfg_t CFG_ERASED = cell_cfg_t'({CFG_W{1'b1}});

  function automatic logic dir_drives(dir_e d);
    return (d == DIR_OUT) || (d == DIR_BIDIR);
  endfunction

  function automatic logic pick_source(src_e s, logic pt, logic [GOE_COUNT-1:0] gn);
    logic r;
    case (s)
      SRC_PT:  r = pt;
      SRC_G0:  r = ~gn[0];
      SRC_G1:  r = ~gn[1];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Returns {enable, value} for the pad.
  function automatic logic [1:0] drive_pad(logic pp, logic en, logic d);
    logic [1:0] r;
    if (pp) r = {en, d};
    else    r = {en & ~d, 1'b0};
    return r;
  endfunction

endpackage

// File: rtl/iocell_cfg_reg.sv
module iocell_cfg_reg
  import iocell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  cell_cfg_t din,
  output cell_cfg_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= CFG_ERASED;
    else if (we) q <= din;
  end

  // R1
  erased_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == CFG_ERASED));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(din)));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/iocell_oe_sel.sv
module iocell_oe_sel
  import iocell_pkg::*;
(
  input  dir_e                 dir,
  input  src_e                 src,
  input  logic                 pt_oe,
  input  logic [GOE_COUNT-1:0] goe_n,
  output logic                 en
);

  logic src_active;
  assign src_active = pick_source(src, pt_oe, goe_n);

  always_comb begin
    case (dir)
      DIR_OUT:   en = 1'b1;
      DIR_BIDIR: en = src_active;
      default:   en = 1'b0;
    endcase
  end

endmodule

// File: rtl/iocell_driver.sv
module iocell_driver
  import iocell_pkg::*;
(
  input  logic push_pull,
  input  logic en,
  input  logic d,
  output logic pad_o,
  output logic pad_oe
);

  logic [1:0] drv;
  assign drv    = drive_pad(push_pull, en, d);
  assign pad_oe = drv[1];
  assign pad_o  = drv[0];

endmodule

// File: rtl/iocell_pin.sv
module iocell_pin
  import iocell_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  cell_cfg_t            cfg_din,
  input  logic [GOE_COUNT-1:0] goe_n,
  input  logic                 pt_oe,
  input  logic                 dout,
  input  logic                 pad_i,
  output logic                 pad_o,
  output logic                 pad_oe,
  output logic                 route_o
);

  cell_cfg_t cfg;
  logic      cell_en;
  logic      mode_drives;

  iocell_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .din   (cfg_din),
    .q     (cfg)
  );

  iocell_oe_sel u_sel (
    .dir   (cfg.dir),
    .src   (cfg.src),
    .pt_oe (pt_oe),
    .goe_n (goe_n),
    .en    (cell_en)
  );

  iocell_driver u_drv (
    .push_pull (cfg.push_pull),
    .en        (cell_en),
    .d         (dout),
    .pad_o     (pad_o),
    .pad_oe    (pad_oe)
  );

  assign mode_drives = dir_drives(cfg.dir);
  assign route_o     = pad_i;

  // R3
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_drives |-> !pad_oe);

  // R8
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.push_pull && pad_oe) |-> !pad_o);

  // R4
  out_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dir == DIR_OUT && cfg.push_pull) |-> pad_oe);

endmodule

// File: rtl/iocell_bank.sv
module iocell_bank
  import iocell_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  cfg_we,
  input  logic [CFG_W-1:0]     cfg_din,
  input  logic [GOE_COUNT-1:0] goe_n,
  input  logic [NUM_PINS-1:0]  pt_oe,
  input  logic [NUM_PINS-1:0]  dout,
  input  logic [NUM_PINS-1:0]  pad_i,
  output logic [NUM_PINS-1:0]  pad_o,
  output logic [NUM_PINS-1:0]  pad_oe,
  output logic [NUM_PINS-1:0]  route_o
);

  cell_cfg_t cfg_word;
  assign cfg_word = cell_cfg_t'(cfg_din);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    iocell_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we[p]),
      .cfg_din (cfg_word),
      .goe_n   (goe_n),
      .pt_oe   (pt_oe[p]),
      .dout    (dout[p]),
      .pad_i   (pad_i[p]),
      .pad_o   (pad_o[p]),
      .pad_oe  (pad_oe[p]),
      .route_o (route_o[p])
    );
  end

endmodule

// File: tb/test_iocell_bank.sv
`timescale 1ns/1ps
module test_iocell_bank;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] cfg_we = '0;
  logic [4:0]   cfg_din = '0;
  logic [1:0]   goe_n = 2'b11;
  logic [N-1:0] pt_oe = '0;
  logic [N-1:0] dout = '0;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] pad_o, pad_oe, route_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iocell_bank #(.NUM_PINS(N)) i_iocell_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_din(cfg_din),
    .goe_n(goe_n), .pt_oe(pt_oe), .dout(dout), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .route_o(route_o)
  );

  // word = {dir[1:0], src[1:0], drive}
  function automatic logic [4:0] cw(logic [1:0] dir, logic [1:0] src, logic drv);
    return {dir, src, drv};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_pin(input string tag, input int p, input logic e_oe, input logic e_o);
    chk(tag, {6'd0, pad_oe[p], pad_o[p]}, {6'd0, e_oe, e_o});
  endtask

  task automatic set_in(input logic [N-1:0] pt, input logic [1:0] g,
                        input logic [N-1:0] d, input logic [N-1:0] pi);
    pt_oe = pt; goe_n = g; dout = d; pad_i = pi;
    #1;
  endtask

  task automatic write_cfg(input logic [N-1:0] mask, input logic [4:0] w);
    @(negedge clk);
    cfg_we = mask; cfg_din = w;
    @(negedge clk);
    cfg_we = '0;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    set_in('1, 2'b00, 3'b101, '0);
    for (int p = 0; p < N; p++) chk_pin("R1 erased input push-pull", p, 1'b0, dout[p]);
  endtask

  task automatic t_input_mode();
    write_cfg(3'b001, cw(2'b00, 2'b11, 1'b1));
    write_cfg(3'b100, cw(2'b11, 2'b01, 1'b0));
    set_in('1, 2'b00, 3'b000, '0);
    chk_pin("R3 dir00 ignores sources", 0, 1'b0, 1'b0);
    chk_pin("R3 dir11 ignores sources", 2, 1'b0, 1'b0);
    set_in('1, 2'b00, 3'b111, '0);
    chk_pin("R3 dir00 dout=1", 0, 1'b0, 1'b1);
  endtask

  task automatic t_output_mode();
    write_cfg(3'b010, cw(2'b01, 2'b00, 1'b1));
    set_in('0, 2'b11, 3'b010, '0);
    chk_pin("R4 R7 out mode drives 1", 1, 1'b1, 1'b1);
    set_in('0, 2'b11, 3'b000, '0);
    chk_pin("R4 R7 out mode drives 0", 1, 1'b1, 1'b0);
  endtask

  task automatic t_bidir_sources();
    write_cfg(3'b100, cw(2'b10, 2'b11, 1'b1));
    set_in(3'b100, 2'b11, 3'b100, '0);
    chk_pin("R5 R6 pt source on", 2, 1'b1, 1'b1);
    set_in(3'b000, 2'b00, 3'b100, '0);
    chk_pin("R6 pt source, globals ignored", 2, 1'b0, 1'b1);
    write_cfg(3'b100, cw(2'b10, 2'b01, 1'b1));
    set_in(3'b000, 2'b10, 3'b000, '0);
    chk_pin("R6 g0 low enables", 2, 1'b1, 1'b0);
    set_in(3'b100, 2'b01, 3'b000, '0);
    chk_pin("R6 g0 high disables", 2, 1'b0, 1'b0);
    write_cfg(3'b100, cw(2'b10, 2'b10, 1'b1));
    set_in(3'b000, 2'b01, 3'b100, '0);
    chk_pin("R6 g1 low enables", 2, 1'b1, 1'b1);
    set_in(3'b100, 2'b10, 3'b100, '0);
    chk_pin("R6 g1 high disables", 2, 1'b0, 1'b1);
    write_cfg(3'b100, cw(2'b10, 2'b00, 1'b1));
    set_in(3'b100, 2'b00, 3'b100, '0);
    chk_pin("R6 src00 never enables", 2, 1'b0, 1'b1);
  endtask

  task automatic t_open_drain();
    write_cfg(3'b001, cw(2'b10, 2'b11, 1'b0));
    set_in(3'b001, 2'b11, 3'b000, '0);
    chk_pin("R8 od low driven", 0, 1'b1, 1'b0);
    set_in(3'b001, 2'b11, 3'b001, '0);
    chk_pin("R8 od high released", 0, 1'b0, 1'b0);
    set_in(3'b000, 2'b11, 3'b000, '0);
    chk_pin("R8 od disabled", 0, 1'b0, 1'b0);
    write_cfg(3'b001, cw(2'b01, 2'b00, 1'b0));
    set_in(3'b000, 2'b11, 3'b000, '0);
    chk_pin("R8 od out mode low", 0, 1'b1, 1'b0);
  endtask

  task automatic t_write_isolation();
    // pin0: out/od, pin1: out/pp, pin2: bidir src00
    write_cfg(3'b010, cw(2'b11, 2'b11, 1'b1));
    set_in('1, 2'b00, 3'b000, '0);
    chk_pin("R2 pin1 now input", 1, 1'b0, 1'b0);
    chk_pin("R2 pin0 untouched", 0, 1'b1, 1'b0);
    chk_pin("R2 pin2 untouched", 2, 1'b0, 1'b0);
    @(negedge clk);
    cfg_din = cw(2'b01, 2'b00, 1'b1);
    repeat (2) @(negedge clk);
    #1;
    chk_pin("R2 no strobe no load", 1, 1'b0, 1'b0);
  endtask

  task automatic t_route();
    set_in('0, 2'b11, 3'b000, 3'b101);
    chk("R9 route follows pad a", {5'd0, route_o}, {5'd0, 3'b101});
    set_in('0, 2'b11, 3'b111, 3'b010);
    chk("R9 route follows pad b", {5'd0, route_o}, {5'd0, 3'b010});
  endtask

  task automatic t_reset_again();
    do_reset();
    set_in('1, 2'b00, 3'b011, '0);
    for (int p = 0; p < N; p++) chk_pin("R1 reset restores erased", p, 1'b0, dout[p]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_input_mode();
    t_output_mode();
    t_bidir_sources();
    t_open_drain();
    t_write_isolation();
    t_route();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog all-R act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule